// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block supervises software by counting slow ticks from one of two prescaler outputs. It starts only when software writes one particular 4-bit key. Further writes of that same key restart the count. If software stops writing the key, a 2-bit counter runs past its top value and the block drives a reset pulse of fixed length into the system reset network.

The tick source is either the fast prescaler or the slow prescaler. Software picks it with a select bit that travels in the same write as the starting key. The choice is then frozen. Once started, the watchdog cannot be turned off by any write. Only the block's own reset input returns it to idle.

Both prescaler outputs arrive as level signals that are synchronous to the system clock. The block finds their rising edges itself. A key write and a tick edge in the same cycle resolve in favour of the key write.

Top module: `keyed_wdog`

## Requirements
- R1: While idle, a write with `wr_key` equal to 4'b0101 starts the watchdog. A write of any other key value leaves it idle, so no tick can then produce a reset pulse.
- R2: Once started, a write of 4'b0101 returns the counter to zero. A write of any other value leaves the count unchanged.
- R3: The reset pulse follows the fourth rising edge of the selected tick after the start or after the latest clear. The timeout therefore spans between three and four tick periods, depending on the phase of the last clear.
- R4: `wr_src` = 0 selects `tick_main` and `wr_src` = 1 selects `tick_sub`. Edges on the unselected tick have no effect on the count.
- R5: The source is captured only by the starting write. The `wr_src` value of any later write is ignored.
- R6: `wdt_rst` rises in the cycle after the clock edge that samples the overflowing tick. It stays high for exactly RST_CYCLES system clocks (4 by default).
- R7: If a key write and a rising tick edge fall in the same cycle while the count is 3, the clear wins and no reset pulse follows.
- R8: After a reset pulse the watchdog keeps running and times out again if not cleared. Only `rst_n` low returns it to idle.
- R9: A tick held high for many cycles advances the count once, on its rising edge.
- R10: After `rst_n` is released, `wdt_rst` is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Software write strobe, one cycle per write |
| wr_key | input | 4 | Key value carried by the write |
| wr_src | input | 1 | Tick source select carried by the write (0 main, 1 sub) |
| tick_main | input | 1 | Fast prescaler output level |
| tick_sub | input | 1 | Slow prescaler output level |
| wdt_rst | output | 1 | Reset request pulse |

## Verification
On every cycle, the assertions check the following:
- the started state never falls back on its own, and the latched source never changes after the start;
- a key write after the start always leaves the counter at zero;
- an overflowing tick always raises the reset output with a full hold count, and that count then steps down by one each cycle;
- no tick produces two edge pulses in consecutive cycles.

Only the bench scenarios can show the following:
- the end-to-end timeout length, counted in tick edges;
- that wrong keys and edges on the unselected source change nothing visible;
- that a clear landing in the same cycle as a tick suppresses the pulse;
- that the watchdog times out again after a pulse and goes idle only on `rst_n`.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_SUB  = 1'b1
    } wdog_src_e;

    localparam int NUM_SRC = 2;
endpackage

// File: rtl/keyed_wdog_key_dec.sv
module keyed_wdog_key_dec #(
    parameter int            KEY_W   = 4,
    parameter logic [KEY_W-1:0] KEY_VAL = 4'b0101
) (
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    output logic             key_hit
);
    always_comb begin
        key_hit = wr_en && (wr_key == KEY_VAL);
    end
endmodule

// File: rtl/keyed_wdog_tick_sel.sv
module keyed_wdog_tick_sel #(
    parameter int N_SRC = keyed_wdog_pkg::NUM_SRC,
    localparam int SW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] tick,
    input  logic [SW-1:0]    sel,
    output logic             tick_pulse
);
    typedef struct packed {
        logic [N_SRC-1:0] prev;
    } ts_t;

    ts_t              q, d;
    logic [N_SRC-1:0] rise;

    always_comb begin
        d      = q;
        d.prev = tick;
        rise   = tick & ~q.prev;
        tick_pulse = rise[sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // each source's edge detector yields isolated single-cycle pulses
    for (genvar i = 0; i < N_SRC; i++) begin : g_src_chk
        assert_single_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/keyed_wdog_core.sv
module keyed_wdog_core #(
    parameter int CNT_W      = 2,
    parameter int RST_CYCLES = 4,
    localparam int RW        = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_hit,
    input  logic src_in,
    input  logic tick_pulse,
    output logic src_sel,
    output logic wdt_rst
);
    import keyed_wdog_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [RW-1:0]    HOLD_LEN = RW'(RST_CYCLES);

    typedef struct packed {
        logic             started;
        wdog_src_e        src;
        logic [CNT_W-1:0] cnt;
        logic [RW-1:0]    hold;
    } core_t;

    core_t q, d;
    logic  overflow;

    always_comb begin
        d        = q;
        overflow = 1'b0;
        if (q.hold != '0) d.hold = q.hold - 1'b1;
        if (!q.started) begin
            if (key_hit) begin
                d.started = 1'b1;
                d.src     = wdog_src_e'(src_in);
                d.cnt     = '0;
            end
        end else if (key_hit) begin
            d.cnt = '0;
        end else if (tick_pulse) begin
            if (q.cnt == CNT_MAX) begin
                overflow = 1'b1;
                d.cnt    = '0;
                d.hold   = HOLD_LEN;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{started: 1'b0, src: SRC_MAIN, cnt: '0, hold: '0};
        else        q <= d;
    end

    assign src_sel = q.src;
    assign wdt_rst = (q.hold != '0);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.started |-> !wdt_rst);
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.started && key_hit) |=> (q.cnt == '0));
    assert_overflow_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.started && tick_pulse && !key_hit && q.cnt == CNT_MAX) |=> (wdt_rst && q.hold == HOLD_LEN));
    assert_src_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.started |=> $stable(q.src));
    assert_hold_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold > 1 && !overflow) |=> (q.hold == $past(q.hold) - 1'b1));
    assert_sticky_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.started |=> q.started);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
    parameter int         KEY_W      = 4,
    parameter logic [3:0] KEY_VAL    = 4'b0101,
    parameter int         CNT_W      = 2,
    parameter int         RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_src,
    input  logic             tick_main,
    input  logic             tick_sub,
    output logic             wdt_rst
);
    import keyed_wdog_pkg::*;

    logic key_hit;
    logic tick_pulse;
    logic src_sel;

    keyed_wdog_key_dec #(
        .KEY_W  (KEY_W),
        .KEY_VAL(KEY_VAL[KEY_W-1:0])
    ) u_key (
        .wr_en  (wr_en),
        .wr_key (wr_key),
        .key_hit(key_hit)
    );

    keyed_wdog_tick_sel #(
        .N_SRC(NUM_SRC)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      ({tick_sub, tick_main}),
        .sel       (src_sel),
        .tick_pulse(tick_pulse)
    );

    keyed_wdog_core #(
        .CNT_W     (CNT_W),
        .RST_CYCLES(RST_CYCLES)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_hit   (key_hit),
        .src_in    (wr_src),
        .tick_pulse(tick_pulse),
        .src_sel   (src_sel),
        .wdt_rst   (wdt_rst)
    );
endmodule

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;
    localparam int RST_CYCLES = 4;
    localparam int TIMEOUT_TICKS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_key = 4'h0;
    logic       wr_src = 1'b0;
    logic       tick_main = 1'b0;
    logic       tick_sub = 1'b0;
    logic       wdt_rst;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    keyed_wdog uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key), .wr_src(wr_src),
        .tick_main(tick_main), .tick_sub(tick_sub), .wdt_rst(wdt_rst)
    );

    typedef struct packed {
        logic [3:0] key;
        logic       src;
        logic [2:0] n_other;
        logic [2:0] n_sel;
        logic [2:0] exp_tick;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{key: 4'h5, src: 1'b0, n_other: 3'd0, n_sel: 3'd4, exp_tick: 3'd4},
        '{key: 4'h5, src: 1'b1, n_other: 3'd0, n_sel: 3'd4, exp_tick: 3'd4},
        '{key: 4'h5, src: 1'b0, n_other: 3'd0, n_sel: 3'd3, exp_tick: 3'd0},
        '{key: 4'h5, src: 1'b0, n_other: 3'd4, n_sel: 3'd4, exp_tick: 3'd4},
        '{key: 4'h5, src: 1'b1, n_other: 3'd5, n_sel: 3'd2, exp_tick: 3'd0},
        '{key: 4'hA, src: 1'b0, n_other: 3'd0, n_sel: 3'd6, exp_tick: 3'd0},
        '{key: 4'h4, src: 1'b1, n_other: 3'd0, n_sel: 3'd6, exp_tick: 3'd0},
        '{key: 4'h5, src: 1'b1, n_other: 3'd3, n_sel: 3'd7, exp_tick: 3'd4}
    };

    task automatic check(input int actual, input int expected, input string what);
        total++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, actual, expected);
        end
    endtask

    task automatic sys_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; tick_main = 1'b0; tick_sub = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write(input logic [3:0] key, input logic src);
        wr_en = 1'b1; wr_key = key; wr_src = src;
        @(negedge clk);
        wr_en = 1'b0; wr_key = 4'h0; wr_src = 1'b0;
        @(negedge clk);
    endtask

    // one rising edge; returns whether wdt_rst came up right after it
    task automatic tick(input logic which, output logic fired);
        if (which) tick_sub = 1'b1; else tick_main = 1'b1;
        @(negedge clk);
        tick_main = 1'b0; tick_sub = 1'b0;
        fired = wdt_rst;
        repeat (RST_CYCLES + 2) @(negedge clk);
    endtask

    task automatic ticks(input logic which, input int n, output int first);
        logic f;
        first = 0;
        for (int i = 1; i <= n; i++) begin
            tick(which, f);
            if (f && first == 0) first = i;
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int   first;
        int   len;
        logic f;

        // R10: reset state
        sys_reset();
        check(int'(wdt_rst), 0, "R10 wdt_rst low after reset");
        ticks(1'b0, 5, first);
        check(first, 0, "R10 idle after reset ignores ticks");

        // table: R1 R3 R4
        for (int v = 0; v < 8; v++) begin
            sys_reset();
            write(VECS[v].key, VECS[v].src);
            ticks(~VECS[v].src, int'(VECS[v].n_other), first);
            check(first, 0, $sformatf("R4 vector %0d unselected ticks", v));
            ticks(VECS[v].src, int'(VECS[v].n_sel), first);
            check(first, int'(VECS[v].exp_tick), $sformatf("R1/R3/R4 vector %0d timeout tick", v));
        end

        // R1: wrong key first, then right key starts
        sys_reset();
        write(4'h3, 1'b0);
        write(4'h5, 1'b0);
        ticks(1'b0, 4, first);
        check(first, TIMEOUT_TICKS, "R1 start after preceding wrong key");

        // R2: clear restarts window
        sys_reset();
        write(4'h5, 1'b0);
        ticks(1'b0, 3, first);
        write(4'h5, 1'b0);
        ticks(1'b0, 3, first);
        check(first, 0, "R2 no timeout after clear");
        tick(1'b0, f);
        check(int'(f), 1, "R2 timeout on fourth tick after clear");

        // R2: wrong key does not clear
        sys_reset();
        write(4'h5, 1'b0);
        ticks(1'b0, 3, first);
        write(4'hA, 1'b0);
        tick(1'b0, f);
        check(int'(f), 1, "R2 wrong key leaves count");

        // R5: later source bit ignored
        sys_reset();
        write(4'h5, 1'b0);
        write(4'h5, 1'b1);
        ticks(1'b1, 4, first);
        check(first, 0, "R5 sub ticks ignored after late select");
        ticks(1'b0, 4, first);
        check(first, TIMEOUT_TICKS, "R5 main source kept");

        // R6: pulse length
        sys_reset();
        write(4'h5, 1'b1);
        ticks(1'b1, 3, first);
        tick_sub = 1'b1;
        @(negedge clk);
        tick_sub = 1'b0;
        len = 0;
        while (wdt_rst && len < 50) begin
            len++;
            @(negedge clk);
        end
        check(len, RST_CYCLES, "R6 pulse length");

        // R7: clear and tick together
        sys_reset();
        write(4'h5, 1'b0);
        ticks(1'b0, 3, first);
        wr_en = 1'b1; wr_key = 4'h5; tick_main = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_key = 4'h0; tick_main = 1'b0;
        check(int'(wdt_rst), 0, "R7 clear beats tick");
        repeat (RST_CYCLES + 2) @(negedge clk);
        ticks(1'b0, 4, first);
        check(first, TIMEOUT_TICKS, "R7 count restarted from zero");

        // R8: keeps running after pulse, idle only on rst_n
        sys_reset();
        write(4'h5, 1'b0);
        ticks(1'b0, 4, first);
        ticks(1'b0, 4, first);
        check(first, TIMEOUT_TICKS, "R8 second timeout after pulse");
        sys_reset();
        ticks(1'b0, 6, first);
        check(first, 0, "R8 rst_n returns to idle");

        // R9: held tick counts once
        sys_reset();
        write(4'h5, 1'b0);
        first = 0;
        for (int k = 1; k <= 3; k++) begin
            tick_main = 1'b1;
            repeat (10) begin
                @(negedge clk);
                if (wdt_rst && first == 0) first = k;
            end
            tick_main = 1'b0;
            repeat (2) @(negedge clk);
        end
        check(first, 0, "R9 held ticks counted once each");
        tick(1'b0, f);
        check(int'(f), 1, "R9 fourth edge times out");

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule